// File: doc/BRIEF.md
# Sized Load/Store Address Unit

This unit turns the load and store instructions of a 64-bit register machine into requests on a simple memory port. For each accepted instruction it decodes the opcode and adds a signed 8-bit displacement to a base register value to form the effective address. For the pool-load form, the displacement is first scaled by eight. The unit then picks a single-byte or an eight-byte access. It places store data on the correct byte lanes and raises the matching byte enables. On a load, it either zero-extends the returned byte or passes the returned quad word through unchanged.

The memory is big-endian. The byte at an address whose low three bits are `o` travels on lane `7-o`, which is bits `[8*(7-o)+7 : 8*(7-o)]`, and byte-enable bit `i` qualifies lane `i`. Only one instruction is in flight at a time. `iss_ready` reports that the unit can accept a new one. A quad-word access whose address is not a multiple of eight is flagged and dropped, so no request is made for it.

Top module: `lsu_addr_unit`

## Requirements
- R1: For opcodes 0x09 (byte load), 0x12 (quad load), 0x11 (byte store) and 0x19 (quad store), `mem_addr` equals `iss_base` plus `iss_disp` sign-extended to 64 bits.
- R2: For opcode 0x17 (pool quad load), `mem_addr` equals `iss_base` plus the sign-extended `iss_disp` multiplied by 8.
- R3: A byte load sets `ld_data[7:0]` to the returned lane `7-o` (where o = `mem_addr[2:0]`) and sets `ld_data[63:8]` to zero.
- R4: A byte store makes one request with `mem_we`=1. Only `mem_be` bit `7-o` is set. `iss_src[7:0]` appears on lane `7-o`, and every other lane of `mem_wdata` is zero.
- R5: A quad access sets all eight `mem_be` bits. A quad store drives `iss_src` unchanged on `mem_wdata`, and a quad load returns `mem_rdata` unchanged on `ld_data`.
- R6: A quad access (0x12, 0x17, 0x19) whose address has nonzero low three bits raises `misalign` for exactly the cycle after issue. It makes no request and leaves `iss_ready` high.
- R7: A request is raised in the cycle after an accepted issue. It holds address, enables, data and direction stable until the clock edge at which `mem_ready` is high, and drops after that edge. `iss_ready` is low exactly while a request is outstanding.
- R8: After the accepting edge of a load, `ld_valid` is high for exactly one cycle. A store never raises `ld_valid`.
- R9: An issue with any other opcode, or an issue made while `iss_ready` is low, has no effect on any output.
- R10: During reset, `mem_req`, `ld_valid` and `misalign` are low and `iss_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Instruction presented this cycle |
| iss_ready | output | 1 | Unit idle, will accept an issue |
| iss_opcode | input | 8 | Instruction opcode |
| iss_base | input | 64 | Base register value |
| iss_disp | input | 8 | Signed displacement |
| iss_src | input | 64 | Store source register value |
| misalign | output | 1 | One-cycle flag for a dropped unaligned quad access |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Effective byte address |
| mem_be | output | 8 | Byte-lane enables, bit i for bits [8i+7:8i] |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_ready | input | 1 | Memory accepts the request at this edge |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| ld_valid | output | 1 | Load result pulse |
| ld_data | output | 64 | Load result for the destination register |

## Verification
A wrong held address, size or direction shows at the memory port in the first request cycle, one cycle after issue. It stays visible for as long as the responder stalls. A lane-selection fault in the load path is hidden until the accepting edge and appears one cycle later on `ld_data`. A stuck busy state shows immediately, as `iss_ready` stays low with no request pending. The bench's reference model therefore compares every output on every cycle while the responder's stall length varies, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   localparam logic [7:0] OPC_LD_BYTE  = 8'h09;
   localparam logic [7:0] OPC_LD_QUAD  = 8'h12;
   localparam logic [7:0] OPC_LD_POOL  = 8'h17;
   localparam logic [7:0] OPC_ST_BYTE  = 8'h11;
   localparam logic [7:0] OPC_ST_QUAD  = 8'h19;

   // decoded view of one memory instruction
   typedef struct packed {
      logic known;    // opcode belongs to this unit
      logic store;    // write access
      logic wide;     // full-word access
      logic scaled;   // displacement scaled by word size
   } lsu_dec_t;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } lsu_state_e;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
(
   input  logic [7:0] opcode,
   output lsu_dec_t   dec
);

   always_comb begin
      dec = '0;
      unique case (opcode)
         OPC_LD_BYTE: dec = '{known: 1'b1, store: 1'b0, wide: 1'b0, scaled: 1'b0};
         OPC_LD_QUAD: dec = '{known: 1'b1, store: 1'b0, wide: 1'b1, scaled: 1'b0};
         OPC_LD_POOL: dec = '{known: 1'b1, store: 1'b0, wide: 1'b1, scaled: 1'b1};
         OPC_ST_BYTE: dec = '{known: 1'b1, store: 1'b1, wide: 1'b0, scaled: 1'b0};
         OPC_ST_QUAD: dec = '{known: 1'b1, store: 1'b1, wide: 1'b1, scaled: 1'b0};
         default:     dec = '0;
      endcase
   end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
   parameter int ADDR_W   = 64,
   parameter int DISP_W   = 8,
   parameter int SCALE_SH = 3,
   parameter int OFS_W    = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   input  logic              scaled,
   input  logic              wide,
   output logic [ADDR_W-1:0] addr,
   output logic              unaligned
);

   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] disp_eff;

   generate
      if (EXT_W > 0) begin : g_ext
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_noext
         assign disp_ext = disp[ADDR_W-1:0];
      end

      if (SCALE_SH > 0) begin : g_scale
         assign disp_eff = scaled ? (disp_ext << SCALE_SH) : disp_ext;
      end else begin : g_noscale
         logic unused_scaled;
         assign unused_scaled = scaled;
         assign disp_eff = disp_ext;
      end
   endgenerate

   assign addr      = base + disp_eff;
   assign unaligned = wide && (addr[OFS_W-1:0] != '0);

endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes #(
   parameter int LANES = 8,
   parameter int OFS_W = 3
) (
   input  logic [OFS_W-1:0]   offset,
   input  logic               wide,
   input  logic               active,
   input  logic [8*LANES-1:0] src,
   input  logic [8*LANES-1:0] rdata,
   output logic [LANES-1:0]   be,
   output logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] ld_data
);

   logic [LANES-1:0] sel;
   logic [7:0]       pick [LANES];

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         // big-endian: byte offset o lives on lane LANES-1-o
         localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(LANES - 1 - i);
         assign sel[i] = wide || (offset == LANE_OFS);
         assign be[i]  = active && sel[i];
         assign wdata[8*i +: 8] = wide ? src[8*i +: 8]
                                       : (sel[i] ? src[7:0] : 8'h00);
         assign pick[i] = sel[i] ? rdata[8*i +: 8] : 8'h00;
      end
   endgenerate

   logic [7:0] byte_val;
   always_comb begin
      byte_val = 8'h00;
      for (int k = 0; k < LANES; k++) begin
         byte_val = byte_val | pick[k];
      end
   end

   assign ld_data = wide ? rdata : {{(8*LANES-8){1'b0}}, byte_val};

endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
   import lsu_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int DATA_W   = 64,
   parameter int DISP_W   = 8,
   parameter int SCALE_SH = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                iss_valid,
   output logic                iss_ready,
   input  logic [7:0]          iss_opcode,
   input  logic [ADDR_W-1:0]   iss_base,
   input  logic [DISP_W-1:0]   iss_disp,
   input  logic [DATA_W-1:0]   iss_src,
   output logic                misalign,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic                mem_ready,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                ld_valid,
   output logic [DATA_W-1:0]   ld_data
);

   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if ((1 << OFS_W) != LANES) begin : g_bad_lanes
         $error("byte lane count must be a power of two");
      end
      if (DISP_W > ADDR_W || DISP_W < 1) begin : g_bad_disp
         $error("DISP_W out of range");
      end
      if (SCALE_SH < 0 || SCALE_SH >= ADDR_W) begin : g_bad_scale
         $error("SCALE_SH out of range");
      end
   endgenerate

   lsu_dec_t          dec;
   logic [ADDR_W-1:0] ea;
   logic              ea_bad;

   lsu_decode u_dec (
      .opcode (iss_opcode),
      .dec    (dec)
   );

   lsu_agen #(
      .ADDR_W   (ADDR_W),
      .DISP_W   (DISP_W),
      .SCALE_SH (SCALE_SH),
      .OFS_W    (OFS_W)
   ) u_agen (
      .base      (iss_base),
      .disp      (iss_disp),
      .scaled    (dec.scaled),
      .wide      (dec.wide),
      .addr      (ea),
      .unaligned (ea_bad)
   );

   lsu_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wide_q;
   logic              store_q;
   logic [DATA_W-1:0] src_q;
   logic              mis_q;
   logic              ldv_q;
   logic [DATA_W-1:0] ld_q;
   logic [DATA_W-1:0] lane_wdata;
   logic [DATA_W-1:0] lane_ld;
   logic [LANES-1:0]  lane_be;

   logic take, accept;
   assign take   = (state_q == ST_IDLE) && iss_valid && dec.known;
   assign accept = (state_q == ST_WAIT) && mem_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wide_q  <= 1'b0;
         store_q <= 1'b0;
         src_q   <= '0;
         mis_q   <= 1'b0;
         ldv_q   <= 1'b0;
         ld_q    <= '0;
      end else begin
         mis_q <= 1'b0;
         ldv_q <= 1'b0;
         if (take) begin
            if (ea_bad) begin
               mis_q <= 1'b1;
            end else begin
               state_q <= ST_WAIT;
               addr_q  <= ea;
               wide_q  <= dec.wide;
               store_q <= dec.store;
               src_q   <= iss_src;
            end
         end
         if (accept) begin
            state_q <= ST_IDLE;
            if (!store_q) begin
               ldv_q <= 1'b1;
               ld_q  <= lane_ld;
            end
         end
      end
   end

   lsu_lanes #(
      .LANES (LANES),
      .OFS_W (OFS_W)
   ) u_lanes (
      .offset  (addr_q[OFS_W-1:0]),
      .wide    (wide_q),
      .active  (state_q == ST_WAIT),
      .src     (src_q),
      .rdata   (mem_rdata),
      .be      (lane_be),
      .wdata   (lane_wdata),
      .ld_data (lane_ld)
   );

   assign iss_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_WAIT);
   assign mem_we    = mem_req && store_q;
   assign mem_addr  = addr_q;
   assign mem_be    = lane_be;
   assign mem_wdata = lane_wdata;
   assign misalign  = mis_q;
   assign ld_valid  = ldv_q;
   assign ld_data   = ld_q;

endmodule

// File: rtl/lsu_addr_unit_chk.sv
module lsu_addr_unit_chk #(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                iss_valid,
   input logic                iss_ready,
   input logic [7:0]          iss_opcode,
   input logic [ADDR_W-1:0]   iss_base,
   input logic                misalign,
   input logic                mem_req,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_be,
   input logic [DATA_W-1:0]   mem_wdata,
   input logic                mem_ready,
   input logic                ld_valid
);

   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;

   logic [DATA_W-1:0] be_bits;
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_mask
         assign be_bits[8*i +: 8] = {8{mem_be[i]}};
      end
   endgenerate

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata) && $stable(mem_we)); // R7
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !iss_ready); // R7
   AST_LDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> !ld_valid); // R8
   AST_LDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(mem_req && mem_ready && !mem_we)); // R8
   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || (&mem_be))); // R4
   AST_BYTE_STORE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && $countones(mem_be) == 1 |-> (mem_wdata & ~be_bits) == '0); // R4
   AST_QUAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && (&mem_be) |-> mem_addr[OFS_W-1:0] == '0); // R6
   AST_MIS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> !mem_req && iss_ready); // R6

endmodule

bind lsu_addr_unit lsu_addr_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .iss_valid  (iss_valid),
   .iss_ready  (iss_ready),
   .iss_opcode (iss_opcode),
   .iss_base   (iss_base),
   .misalign   (misalign),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_be     (mem_be),
   .mem_wdata  (mem_wdata),
   .mem_ready  (mem_ready),
   .ld_valid   (ld_valid)
);

// File: tb/lsu_addr_unit_tb_top.sv
module lsu_addr_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic        iss_ready;
   logic [7:0]  iss_opcode = 8'h00;
   logic [63:0] iss_base = '0;
   logic [7:0]  iss_disp = '0;
   logic [63:0] iss_src = '0;
   logic        misalign;
   logic        mem_req;
   logic        mem_we;
   logic [63:0] mem_addr;
   logic [7:0]  mem_be;
   logic [63:0] mem_wdata;
   logic        mem_ready = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        ld_valid;
   logic [63:0] ld_data;

   int checks = 0;
   int fails  = 0;
   int stall_len = 0;
   int wcnt = 0;

   always #10 clk = ~clk;   // 50 MHz

   lsu_addr_unit dut_i (.*);

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_busy, m_we, m_wide, m_mis, m_ldv, m_ign;
   logic [7:0]  m_op;
   logic [63:0] m_addr, m_src, m_ld;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_we = 0; m_wide = 0; m_mis = 0; m_ldv = 0; m_ign = 0;
         m_op = 0; m_addr = 0; m_src = 0; m_ld = 0;
      end else begin
         m_mis = 0;
         m_ign = 0;
         if (m_busy) begin
            m_ldv = 0;
            if (iss_valid) m_ign = 1;
            if (mem_ready) begin
               m_busy = 0;
               if (!m_we) begin
                  m_ldv = 1;
                  m_ld  = m_wide ? mem_rdata
                                 : ((mem_rdata >> (8 * (7 - int'(m_addr % 8)))) & 64'hFF);
               end
            end
         end else begin
            m_ldv = 0;
            if (iss_valid) begin
               bit known, w, st;
               longint d;
               known = 1; w = 0; st = 0;
               d = longint'($signed(iss_disp));
               case (iss_opcode)
                  8'h09: ;
                  8'h12: w = 1;
                  8'h17: begin w = 1; d = d * 8; end
                  8'h11: st = 1;
                  8'h19: begin w = 1; st = 1; end
                  default: known = 0;
               endcase
               if (!known) m_ign = 1;
               else begin
                  logic [63:0] a;
                  a = iss_base + 64'(d);
                  if (w && (a % 8) != 0) m_mis = 1;
                  else begin
                     m_busy = 1; m_addr = a; m_wide = w; m_we = st;
                     m_src = iss_src; m_op = iss_opcode;
                  end
               end
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (!rst_n) begin
         chk(mem_req == 1'b0, "R10 mem_req", 64'(mem_req), 0);
         chk(ld_valid == 1'b0, "R10 ld_valid", 64'(ld_valid), 0);
         chk(misalign == 1'b0, "R10 misalign", 64'(misalign), 0);
         chk(iss_ready == 1'b1, "R10 iss_ready", 64'(iss_ready), 1);
      end else begin
         chk(mem_req == m_busy, m_ign ? "R9 mem_req" : "R7 mem_req", 64'(mem_req), 64'(m_busy));
         chk(iss_ready == !m_busy, "R7 iss_ready", 64'(iss_ready), 64'(!m_busy));
         chk(misalign == m_mis, m_ign ? "R9 misalign" : "R6 misalign", 64'(misalign), 64'(m_mis));
         chk(ld_valid == m_ldv, m_ign ? "R9 ld_valid" : "R8 ld_valid", 64'(ld_valid), 64'(m_ldv));
         if (m_busy) begin
            logic [7:0]  eb;
            logic [63:0] ew;
            int lane;
            lane = 7 - int'(m_addr % 8);
            eb = m_wide ? 8'hFF : 8'(1 << lane);
            ew = m_wide ? m_src : ({56'h0, m_src[7:0]} << (8 * lane));
            chk(mem_addr == m_addr, (m_op == 8'h17) ? "R2 mem_addr" : "R1 mem_addr",
                mem_addr, m_addr);
            chk(mem_we == m_we, "R7 mem_we", 64'(mem_we), 64'(m_we));
            chk(mem_be == eb, m_wide ? "R5 mem_be" : "R4 mem_be", 64'(mem_be), 64'(eb));
            if (m_we)
               chk(mem_wdata == ew, m_wide ? "R5 mem_wdata" : "R4 mem_wdata", mem_wdata, ew);
         end
         if (m_ldv)
            chk(ld_data == m_ld, m_wide ? "R5 ld_data" : "R3 ld_data", ld_data, m_ld);
      end
   end

   // ---------------- memory responder ----------------
   always @(negedge clk) begin
      if (mem_req) begin
         if (wcnt == 0) begin
            mem_ready = 1'b1;
            mem_rdata = {$urandom, $urandom};
         end else begin
            mem_ready = 1'b0;
            wcnt--;
         end
      end else begin
         mem_ready = 1'b0;
         wcnt = stall_len;
      end
   end

   task automatic issue(input logic [7:0] op, input logic [63:0] b,
                        input logic [7:0] d, input logic [63:0] s);
      @(negedge clk);
      while (!iss_ready) @(negedge clk);
      iss_valid = 1'b1; iss_opcode = op; iss_base = b; iss_disp = d; iss_src = s;
      @(negedge clk);
      iss_valid = 1'b0;
   endtask

   function automatic logic [7:0] pick_op(int r);
      case (r % 7)
         0: return 8'h09;
         1: return 8'h12;
         2: return 8'h17;
         3: return 8'h11;
         4: return 8'h19;
         5: return 8'h0A;
         default: return 8'h00;
      endcase
   endfunction

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            // directed: each form, both displacement signs, lane boundaries
            issue(8'h09, 64'h1000, 8'h03, 0);           // R1 R3
            issue(8'h09, 64'h1007, 8'h00, 0);           // R3 lane 0
            issue(8'h12, 64'h2010, 8'hF8, 0);           // R1 negative disp, R5
            issue(8'h17, 64'h3000, 8'hFF, 0);           // R2 disp -1 scaled
            issue(8'h17, 64'h3000, 8'h7F, 0);           // R2 positive max
            issue(8'h11, 64'h4000, 8'h05, 64'h1122334455667788); // R4
            issue(8'h19, 64'h5008, 8'h08, 64'hCAFEF00DDEADBEEF); // R5
            issue(8'h12, 64'h6001, 8'h00, 0);           // R6
            issue(8'h17, 64'h6003, 8'h01, 0);           // R6 base unaligned
            issue(8'h3C, 64'h7000, 8'h00, 0);           // R9 unknown op
            stall_len = 3;
            issue(8'h12, 64'h8000, 8'h10, 0);           // R7 stall hold
            // R9: issue while busy
            issue(8'h19, 64'h9000, 8'h00, 64'h55);
            iss_valid = 1'b1; iss_opcode = 8'h09; iss_base = 64'hA000;
            @(negedge clk);
            iss_valid = 1'b0;
            // random traffic
            for (int n = 0; n < 3000; n++) begin
               if (n % 50 == 0) stall_len = $urandom_range(0, 3);
               iss_valid  = ($urandom % 3) == 0;
               iss_opcode = pick_op($urandom);
               iss_base   = {$urandom, $urandom} & (($urandom % 2) ? ~64'h7 : ~64'h0);
               iss_disp   = 8'($urandom);
               iss_src    = {$urandom, $urandom};
               @(negedge clk);
            end
            iss_valid = 1'b0;
            repeat (10) @(negedge clk);
         end
         begin
            repeat (100000) @(posedge clk);
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule